// File: doc/BRIEF.md
# Asynchronous Character Transmitter

This block takes one character at a time from a single-entry holding register and sends it on an asynchronous serial line. The line rests high. Each character goes out as a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period. A clock-enable pulse at sixteen times the bit rate sets all timing, and every bit lasts sixteen of these pulses.

The host writes a character with a one-cycle strobe. If the shifter is idle, the character moves into it on the next clock and the holding register reports empty again at once. The host can then queue the next character while the current one is still on the line. A queued character follows the previous stop period with no idle gap. Two flags report progress: holding-register-empty tells the host it may write, and transmitter-empty tells it that the line has returned to rest.

Character length, parity and stop length are read when a character enters the shifter. They can be changed while a frame is on the line without disturbing that frame.

Top module: `async_char_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is 1 and both `thr_empty` and `tx_empty` are 1.
- R2: A frame begins with `tx_line` low for 16 ticks. The data bits follow, bit 0 first, each held for exactly 16 ticks.
- R3: `cfg_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Holding-register bits at or above that count are never sent.
- R4: With `cfg_par_en`=1, a parity bit of 16 ticks follows the data. With `cfg_par_even`=1 the parity bit makes the count of ones in data plus parity even; with `cfg_par_even`=0 it makes that count odd. With `cfg_par_en`=0 no parity bit is sent.
- R5: The stop period keeps `tx_line` at 1. It lasts 16 ticks when `cfg_long_stop`=0. When `cfg_long_stop`=1 it lasts 24 ticks for 5-bit characters and 32 ticks for 6- to 8-bit characters.
- R6: `thr_empty` is 0 in the cycle after a write. The character moves into an idle shifter on the next clock edge, and `thr_empty` returns to 1 on that same edge.
- R7: `tx_empty` falls on the edge where a character is loaded, which is the same edge where `tx_line` goes low. It rises only on the edge that ends the final stop tick.
- R8: When a character is waiting at the end of a stop period, its start bit begins on the edge that ends that stop period, and `tx_empty` stays 0 throughout.
- R9: A write while the holding register is full replaces the pending character. Only the newest character is sent.
- R10: Configuration inputs are captured at load. Changing them during a frame has no effect on that frame.
- R11: Bit timing advances only on cycles with `tick16`=1. When ticks arrive every P cycles, each bit after the start bit lasts 16·P cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| thr_wr | input | 1 | One-cycle write strobe for the holding register |
| thr_data | input | 8 | Character to transmit |
| cfg_len | input | 2 | Character length code (0..3 gives 5..8 bits) |
| cfg_par_en | input | 1 | Adds a parity bit when set |
| cfg_par_even | input | 1 | Even parity when 1, odd parity when 0 |
| cfg_long_stop | input | 1 | Long stop period (1.5 or 2 bits) when set |
| tx_line | output | 1 | Serial output, high at rest |
| thr_empty | output | 1 | Holding register can accept a character |
| tx_empty | output | 1 | No frame in progress and nothing pending |

## Verification
The assertions check these rules on every cycle:
- a write always leaves the holding register full on the next cycle;
- the line is high while the transmitter is empty and during every stop period;
- a load always drops the line and clears transmitter-empty on the same edge;
- the tick counter holds still without a tick and stays below the limit for the current bit.

Some behaviour depends on the configuration that was latched and on what the host writes, so only the bench scenarios can show it:
- the exact bit values, parity polarity and stop length for each combination of length, parity and stop option;
- the gap-free hand-over to a queued character;
- overwriting a pending character;
- immunity to configuration changes in mid-frame;
- the stretched timing under a slow tick.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

endpackage

// File: rtl/tx_holding_reg.sv
module tx_holding_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              take_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
    } hold_t;

    hold_t q, d;

    always_comb begin
        d = q;
        if (wr_i) begin
            d.data = wr_data_i;
            d.full = 1'b1;
        end else if (take_i) begin
            d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign data_o = q.data;
    assign full_o = q.full;

    // R6: a write always leaves a pending character behind
    assert_wr_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> full_o);

endmodule

// File: rtl/tx_tick_timer.sv
module tx_tick_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             done_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t q, d;
    logic at_end;

    assign at_end = (q.cnt == limit_i - CNT_W'(1));

    always_comb begin
        d = q;
        if (clear_i) begin
            d.cnt = '0;
        end else if (tick_i) begin
            if (at_end) begin
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o = tick_i && !clear_i && at_end;

    // R11: without a tick the bit timer does not move
    assert_cnt_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clear_i) |=> $stable(q.cnt));

    // R2: the tick count stays inside the current bit period
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < limit_i);

endmodule

// File: rtl/tx_framer.sv
module tx_framer
    import async_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2,
    parameter int TPB    = 16,
    parameter int CNT_W  = $clog2(2 * TPB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_full_i,
    input  logic [DATA_W-1:0] hold_data_i,
    input  logic [LEN_W-1:0]  cfg_len_i,
    input  logic              cfg_par_en_i,
    input  logic              cfg_par_even_i,
    input  logic              cfg_long_stop_i,
    input  logic              done_i,
    output logic              load_o,
    output logic              clear_o,
    output logic [CNT_W-1:0]  limit_o,
    output logic              line_o,
    output logic              idle_o
);

    localparam int IDX_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int MIN_BITS = DATA_W - (1 << LEN_W) + 1;
    localparam int STOP_STD = TPB;
    localparam int STOP_MID = TPB + TPB / 2;
    localparam int STOP_MAX = 2 * TPB;

    typedef struct packed {
        tx_state_e         state;
        logic [DATA_W-1:0] shreg;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last_idx;
        logic              par_en;
        logic              par_bit;
        logic [CNT_W-1:0]  stop_len;
        logic              line;
        logic              idle;
    } fr_t;

    fr_t q, d;

    logic [IDX_W-1:0]  new_last;
    logic [DATA_W-1:0] new_mask;
    logic [DATA_W-1:0] new_data;
    logic [CNT_W-1:0]  new_stop;
    logic              do_load;

    assign new_last = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_len_i);

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            new_mask[i] = (i <= int'(new_last));
        end
    end

    assign new_data = hold_data_i & new_mask;

    always_comb begin
        if (!cfg_long_stop_i) begin
            new_stop = CNT_W'(STOP_STD);
        end else if (cfg_len_i == '0) begin
            new_stop = CNT_W'(STOP_MID);
        end else begin
            new_stop = CNT_W'(STOP_MAX);
        end
    end

    always_comb begin
        d       = q;
        do_load = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (hold_full_i) begin
                    do_load = 1'b1;
                end
            end
            ST_START: begin
                if (done_i) begin
                    d.state = ST_DATA;
                    d.line  = q.shreg[0];
                    d.shreg = q.shreg >> 1;
                    d.idx   = '0;
                end
            end
            ST_DATA: begin
                if (done_i) begin
                    if (q.idx == q.last_idx) begin
                        if (q.par_en) begin
                            d.state = ST_PARITY;
                            d.line  = q.par_bit;
                        end else begin
                            d.state = ST_STOP;
                            d.line  = 1'b1;
                        end
                    end else begin
                        d.idx   = q.idx + IDX_W'(1);
                        d.line  = q.shreg[0];
                        d.shreg = q.shreg >> 1;
                    end
                end
            end
            ST_PARITY: begin
                if (done_i) begin
                    d.state = ST_STOP;
                    d.line  = 1'b1;
                end
            end
            ST_STOP: begin
                if (done_i) begin
                    if (hold_full_i) begin
                        do_load = 1'b1;
                    end else begin
                        d.state = ST_IDLE;
                        d.line  = 1'b1;
                        d.idle  = 1'b1;
                    end
                end
            end
            default: begin
                d.state = ST_IDLE;
                d.line  = 1'b1;
                d.idle  = 1'b1;
            end
        endcase

        if (do_load) begin
            d.state    = ST_START;
            d.shreg    = new_data;
            d.idx      = '0;
            d.last_idx = new_last;
            d.par_en   = cfg_par_en_i;
            d.par_bit  = (^new_data) ^ !cfg_par_even_i;
            d.stop_len = new_stop;
            d.line     = 1'b0;
            d.idle     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.state    <= ST_IDLE;
            q.stop_len <= CNT_W'(STOP_STD);
            q.line     <= 1'b1;
            q.idle     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign load_o  = do_load;
    assign clear_o = (q.state == ST_IDLE);
    assign limit_o = (q.state == ST_STOP) ? q.stop_len : CNT_W'(TPB);
    assign line_o  = q.line;
    assign idle_o  = q.idle;

    // R1: the line rests high whenever nothing is being sent
    assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q.idle |-> q.line);

    // R5: the stop period never drives the line low
    assert_stop_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_STOP) |-> q.line);

endmodule

// File: rtl/async_char_tx.sv
module async_char_tx #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2,
    parameter int TPB    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              thr_wr,
    input  logic [DATA_W-1:0] thr_data,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_long_stop,
    output logic              tx_line,
    output logic              thr_empty,
    output logic              tx_empty
);

    localparam int CNT_W = $clog2(2 * TPB + 1);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              load;
    logic              clear;
    logic              done;
    logic [CNT_W-1:0]  limit;

    tx_holding_reg #(.DATA_W(DATA_W)) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (thr_wr),
        .wr_data_i (thr_data),
        .take_i    (load),
        .data_o    (hold_data),
        .full_o    (hold_full)
    );

    tx_tick_timer #(.CNT_W(CNT_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick16),
        .clear_i (clear),
        .limit_i (limit),
        .done_o  (done)
    );

    tx_framer #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W),
        .TPB    (TPB),
        .CNT_W  (CNT_W)
    ) framer_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .hold_full_i     (hold_full),
        .hold_data_i     (hold_data),
        .cfg_len_i       (cfg_len),
        .cfg_par_en_i    (cfg_par_en),
        .cfg_par_even_i  (cfg_par_even),
        .cfg_long_stop_i (cfg_long_stop),
        .done_i          (done),
        .load_o          (load),
        .clear_o         (clear),
        .limit_o         (limit),
        .line_o          (tx_line),
        .idle_o          (tx_empty)
    );

    assign thr_empty = !hold_full;

    // R7: leaving the empty state always coincides with a start bit
    assert_start_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> !tx_line);

    // R6: the holding register only frees up by loading the shifter
    assert_load_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(thr_empty) |-> !tx_empty);

endmodule

// File: tb/async_char_tx_tb.sv
module async_char_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       thr_wr = 1'b0;
    logic [7:0] thr_data = '0;
    logic [1:0] cfg_len = '0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_long_stop = 1'b0;
    logic       tx_line;
    logic       thr_empty;
    logic       tx_empty;

    int n_checks = 0;
    int n_err = 0;
    int tick_period = 1;
    int tick_ctr = 0;
    int cycles = 0;

    async_char_tx dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick16        (tick16),
        .thr_wr        (thr_wr),
        .thr_data      (thr_data),
        .cfg_len       (cfg_len),
        .cfg_par_en    (cfg_par_en),
        .cfg_par_even  (cfg_par_even),
        .cfg_long_stop (cfg_long_stop),
        .tx_line       (tx_line),
        .thr_empty     (thr_empty),
        .tx_empty      (tx_empty)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        forever begin
            @(negedge clk);
            if (tick_ctr >= tick_period - 1) begin
                tick_ctr = 0;
                tick16   = 1'b1;
            end else begin
                tick_ctr = tick_ctr + 1;
                tick16   = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    function automatic int stop_ticks(input int len, input bit ls);
        if (!ls) return 16;
        return (len == 0) ? 24 : 32;
    endfunction

    function automatic bit par_val(input logic [7:0] data, input int nb, input bit ev);
        bit x = 1'b0;
        for (int i = 0; i < nb; i++) x ^= data[i];
        return x ^ !ev;
    endfunction

    task automatic set_cfg(input int len, input bit pe, input bit pev, input bit ls);
        cfg_len       = 2'(len);
        cfg_par_en    = pe;
        cfg_par_even  = pev;
        cfg_long_stop = ls;
    endtask

    // Called at the negedge where the start bit was first seen (c = 0).
    task automatic follow_frame(input int len, input bit pe, input bit pev, input bit ls,
                                input logic [7:0] data, input bit next_pending);
        int nb    = 5 + len;
        int sbase = 16 * (1 + nb + (pe ? 1 : 0));
        int total = sbase + stop_ticks(len, ls);
        for (int c = 1; c <= total; c++) begin
            @(negedge clk);
            if (c == 8) chk("R2 start bit low", tx_line, 0);
            for (int j = 0; j < nb; j++) begin
                if (c == 8 + 16 * (j + 1)) chk("R2/R3 data bit", tx_line, data[j]);
            end
            if (pe && c == 8 + 16 * (nb + 1)) chk("R4 parity bit", tx_line, par_val(data, nb, pev));
            if (c == sbase) chk("R3/R4 stop begins after last bit", tx_line, 1);
            if (c == total - 1) begin
                chk("R5 stop still high", tx_line, 1);
                chk("R7 tx_empty low until stop ends", tx_empty, 0);
            end
            if (c == total) begin
                if (next_pending) begin
                    chk("R8 next start bit immediate", tx_line, 0);
                    chk("R8 tx_empty stays low", tx_empty, 0);
                end else begin
                    chk("R5/R7 tx_empty after stop", tx_empty, 1);
                    chk("R1 line idle high", tx_line, 1);
                    chk("R1 thr_empty idle", thr_empty, 1);
                end
            end
        end
    endtask

    task automatic write_and_start(input logic [7:0] data);
        @(negedge clk);
        thr_wr   = 1'b1;
        thr_data = data;
        @(negedge clk);
        thr_wr = 1'b0;
        chk("R6 thr_empty clears after write", thr_empty, 0);
        chk("R6 line idle before load", tx_line, 1);
        @(negedge clk);
        chk("R6 thr_empty set at load", thr_empty, 1);
        chk("R7 tx_empty falls at load", tx_empty, 0);
        chk("R2 line low at load", tx_line, 0);
    endtask

    task automatic send_frame(input int len, input bit pe, input bit pev, input bit ls,
                              input logic [7:0] data);
        set_cfg(len, pe, pev, ls);
        write_and_start(data);
        // R10: scramble configuration during the frame
        set_cfg(3 - len, !pe, !pev, !ls);
        follow_frame(len, pe, pev, ls, data, 1'b0);
    endtask

    initial begin
        logic [7:0] pats [4];
        pats[0] = 8'h00;
        pats[1] = 8'hFF;
        pats[2] = 8'hA5;
        pats[3] = 8'h3C;

        repeat (3) @(negedge clk);
        chk("R1 reset line", tx_line, 1);
        chk("R1 reset thr_empty", thr_empty, 1);
        chk("R1 reset tx_empty", tx_empty, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle line", tx_line, 1);

        // Sweep of length, parity and stop settings
        for (int len = 0; len < 4; len++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int ls = 0; ls < 2; ls++) begin
                    for (int k = 0; k < 4; k++) begin
                        logic [7:0] dv = pats[k] ^ 8'(len * 37 + pm * 11 + ls * 5);
                        send_frame(len, pm != 0, pm == 2, ls != 0, dv);
                    end
                end
            end
        end

        // R8 back-to-back and R9 overwrite of pending character
        set_cfg(3, 1'b0, 1'b0, 1'b0);
        write_and_start(8'h5A);
        thr_wr   = 1'b1;
        thr_data = 8'h11;
        @(negedge clk);
        chk("R6 pending makes thr_empty low", thr_empty, 0);
        thr_data = 8'hC3;
        @(negedge clk);
        thr_wr = 1'b0;
        chk("R9 still pending after overwrite", thr_empty, 0);
        begin
            int total = 16 * 9 + 16;
            for (int c = 3; c <= total; c++) begin
                @(negedge clk);
                if (c == 8 + 16 * 1) chk("R2 first frame bit0", tx_line, 0);
                if (c == total - 1) chk("R8 pending kept through stop", thr_empty, 0);
                if (c == total) begin
                    chk("R8 next start bit immediate", tx_line, 0);
                    chk("R8 tx_empty stays low", tx_empty, 0);
                    chk("R8 pending loaded", thr_empty, 1);
                end
            end
        end
        follow_frame(3, 1'b0, 1'b0, 1'b0, 8'hC3, 1'b0);

        // R11 slow tick: one tick every 3 cycles, 7 bits, even parity, 2 stop bits
        tick_period = 3;
        set_cfg(2, 1'b1, 1'b1, 1'b1);
        write_and_start(8'h4D);
        begin
            int p = 3;
            int dur = 0;
            int frame = (16 * (1 + 7 + 1) + 32) * p;
            for (int c = 1; c <= frame + 10; c++) begin
                @(negedge clk);
                for (int j = 0; j < 7; j++) begin
                    if (c == 16 * p * (j + 1) + 8 * p) chk("R11 data bit slow tick", tx_line, 8'h4D >> j & 1);
                end
                if (c == 16 * p * 8 + 8 * p) chk("R11 parity slow tick", tx_line, par_val(8'h4D, 7, 1'b1));
                if (dur == 0 && tx_empty) dur = c;
            end
            chk("R11 frame length lower bound", int'(dur >= frame - (p - 1)), 1);
            chk("R11 frame length upper bound", int'(dur <= frame), 1);
        end
        tick_period = 1;
        repeat (5) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule